// File: doc/BRIEF.md
# Multichannel DMA Register and Interrupt Unit

This block is the register front end of a DMA controller. A bus master reaches it through a 4 KB window on a simple single-cycle slave port. The window holds global interrupt status, clear and enable views, a global configuration word, a source, destination and configuration word for each channel, and a read-only block of identification bytes. The block does not move any data. Each channel has a done strobe and an error strobe that latch terminal-count and error status. A single interrupt line reports any status bit that its channel has unmasked.

The parameter `NUM_CH` selects 8 or 2 channels. It bounds the per-channel decode, the width of every status bitmap and the first identification byte. Accesses that no register claims are answered with zero and a decode-error pulse. Writes that ask for an unsupported feature are stored where storage exists and raise a one-cycle unsupported pulse.

Timing follows one rule. An access is taken in the cycle where `selIn` is high. Read data, `decErrOut` and `unsupOut` appear in the following cycle. Register state and `irqOut` also change in that following cycle.

Top module: `dmac_regif`

## Requirements
- R1: Channel c (c < NUM_CH) occupies byte offsets 0x100+32c upward, with source address at +0x0, destination address at +0x4 and configuration at +0x8. Source and destination read back the full 32-bit value written. Configuration keeps bits [15:0] and reads 0 above them.
- R2: A read returns 0 and a write changes no state, and `decErrOut` is high for the single cycle after the access, in these cases:
  - a channel index (offset bits [7:5]) at or above NUM_CH in 0x100–0x1FF;
  - an unused word inside a channel stride;
  - an unused word in 0x000–0x0FF;
  - any offset in 0x200–0xFDF;
  - a write to 0xFE0–0xFFF.
- R3: A read of 0xFE0+4k (k = 0..7) returns, in bits [7:0], byte k of 0x80,0x10,0x04,0x0A,0x0D,0xF0,0x05,0xB1. With NUM_CH = 2 the first byte is 0x81 instead.
- R4: The global configuration word at 0x030 keeps bits [2:0] and reads them back. Bit 0 is the controller enable and drives `ctrlEnOut`. A write with bit 1 or bit 2 set (the endianness selects) makes `unsupOut` high in the next cycle.
- R5: A high `chanDoneIn[c]` or `chanErrIn[c]` sets bit c of the raw terminal-count status (read at 0x014) or the raw error status (read at 0x018), respectively.
- R6: Writing ones to 0x008 clears the matching raw terminal-count bits, and writing ones to 0x010 clears the matching raw error bits. A strobe on the same channel in the same cycle wins, and the bit stays set.
- R7: Per-channel masks:
  - The terminal-count mask of channel c is bit 14 of its configuration word, and the error mask is bit 15.
  - 0x004 reads terminal-count status AND mask, and 0x00C reads error status AND mask.
  - 0x000 reads the OR of those two views.
  - `irqOut` is high exactly when that OR is nonzero.
- R8: 0x01C reads a bitmap with bit c set when bit 0 (channel enable) of channel c's configuration word is set.
- R9: A configuration write whose flow field (bits [13:11]) is 4 or more makes `unsupOut` high in the next cycle, and the value is still stored.
- R10: Writes to the software burst request (0x020) and software single request (0x024) words make `unsupOut` high in the next cycle and change nothing else. Reads of these words return 0.
- R11: After reset:
  - every register and status bit is 0;
  - `irqOut`, `ctrlEnOut`, `decErrOut` and `unsupOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selIn | input | 1 | Access valid this cycle |
| wrIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | 12 | Byte offset in the window |
| wdataIn | input | 32 | Write data |
| chanDoneIn | input | NUM_CH | Per-channel transfer-done strobe |
| chanErrIn | input | NUM_CH | Per-channel error strobe |
| rdataOut | output | 32 | Read data, valid the cycle after a read |
| decErrOut | output | 1 | Bad-offset pulse |
| unsupOut | output | 1 | Unsupported-request pulse |
| irqOut | output | 1 | Combined interrupt |
| ctrlEnOut | output | 1 | Global controller enable |

## Verification
The assertions assume two things about the inputs:
- an access lasts exactly one cycle, with `addrIn`, `wrIn` and `wdataIn` meaningful only while `selIn` is high;
- each strobe is a level sampled at each edge, not an event.

The bench keeps within this by driving every access and strobe for a single cycle, set up on the falling edge, and by returning `selIn` and the strobes to zero afterwards. Word-aligned offsets are used throughout, so the ignored low address bits never matter.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_COMB, RK_TCMSK, RK_TCCLR, RK_ERRMSK, RK_ERRCLR,
    RK_TCRAW, RK_ERRRAW, RK_ENABLED, RK_SOFTREQ, RK_GCFG,
    RK_SRC, RK_DST, RK_CFG, RK_ID
  } regKind_e;

  typedef struct packed {
    logic     rdEn;
    logic     wrEn;
    logic     bad;
    regKind_e kind;
    logic [2:0] chan;
    logic [2:0] idIdx;
  } busCmd_t;

  localparam int CFG_W      = 16;
  localparam int CFG_EN     = 0;
  localparam int CFG_FLOW_H = 13;
  localparam int CFG_TCM    = 14;
  localparam int CFG_ERRM   = 15;
  localparam int GCFG_W     = 3;

  function automatic logic [7:0] idByte(input int numCh, input logic [2:0] idx);
    case (idx)
      3'd0: return (numCh == 2) ? 8'h81 : 8'h80;
      3'd1: return 8'h10;
      3'd2: return 8'h04;
      3'd3: return 8'h0A;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic        selIn,
  input  logic        wrIn,
  input  logic [11:0] addrIn,
  output busCmd_t     cmdOut
);
  localparam logic [3:0] NCH4 = 4'(NUM_CH);

  regKind_e kind;
  logic     decodeBad;

  always_comb begin
    kind      = RK_NONE;
    decodeBad = 1'b0;
    if (addrIn >= 12'hFE0) begin
      kind      = RK_ID;
      decodeBad = wrIn;
    end else if (addrIn[11:8] == 4'h1) begin
      if ({1'b0, addrIn[7:5]} >= NCH4) begin
        decodeBad = 1'b1;
      end else begin
        case (addrIn[4:2])
          3'd0:    kind = RK_SRC;
          3'd1:    kind = RK_DST;
          3'd2:    kind = RK_CFG;
          default: decodeBad = 1'b1;
        endcase
      end
    end else if (addrIn[11:8] == 4'h0) begin
      case (addrIn[7:2])
        6'd0:       kind = RK_COMB;
        6'd1:       kind = RK_TCMSK;
        6'd2:       kind = RK_TCCLR;
        6'd3:       kind = RK_ERRMSK;
        6'd4:       kind = RK_ERRCLR;
        6'd5:       kind = RK_TCRAW;
        6'd6:       kind = RK_ERRRAW;
        6'd7:       kind = RK_ENABLED;
        6'd8, 6'd9: kind = RK_SOFTREQ;
        6'd12:      kind = RK_GCFG;
        default:    decodeBad = 1'b1;
      endcase
    end else begin
      decodeBad = 1'b1;
    end
  end

  always_comb begin
    cmdOut.bad   = selIn & decodeBad;
    cmdOut.rdEn  = selIn & ~wrIn & ~decodeBad;
    cmdOut.wrEn  = selIn & wrIn & ~decodeBad;
    cmdOut.kind  = decodeBad ? RK_NONE : kind;
    cmdOut.chan  = addrIn[7:5];
    cmdOut.idIdx = addrIn[4:2];
  end

endmodule

// File: rtl/dmac_dp.sv
module dmac_dp
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmdIn,
  input  logic [31:0]       wdataIn,
  input  logic [NUM_CH-1:0] chanDoneIn,
  input  logic [NUM_CH-1:0] chanErrIn,
  output logic [31:0]       rdataOut,
  output logic              decErrOut,
  output logic              unsupOut,
  output logic              irqOut,
  output logic              ctrlEnOut,
  output logic [NUM_CH-1:0] tcRawOut,
  output logic [NUM_CH-1:0] errRawOut
);
  logic [31:0]       srcQ [NUM_CH];
  logic [31:0]       dstQ [NUM_CH];
  logic [CFG_W-1:0]  cfgQ [NUM_CH];
  logic [GCFG_W-1:0] gcfgQ;
  logic [NUM_CH-1:0] tcQ, errQ;
  logic [NUM_CH-1:0] tcMask, errMask, enMap;
  logic [NUM_CH-1:0] tcClr, errClr;
  logic [31:0]       rdNext;
  logic              unsupNext;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign tcMask[c]  = cfgQ[c][CFG_TCM];
    assign errMask[c] = cfgQ[c][CFG_ERRM];
    assign enMap[c]   = cfgQ[c][CFG_EN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        srcQ[c] <= '0;
        dstQ[c] <= '0;
        cfgQ[c] <= '0;
      end
    end else if (cmdIn.wrEn) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cmdIn.chan == 3'(c)) begin
          if (cmdIn.kind == RK_SRC) srcQ[c] <= wdataIn;
          if (cmdIn.kind == RK_DST) dstQ[c] <= wdataIn;
          if (cmdIn.kind == RK_CFG) cfgQ[c] <= wdataIn[CFG_W-1:0];
        end
      end
    end
  end

  always_comb begin
    tcClr  = (cmdIn.wrEn && cmdIn.kind == RK_TCCLR)  ? wdataIn[NUM_CH-1:0] : '0;
    errClr = (cmdIn.wrEn && cmdIn.kind == RK_ERRCLR) ? wdataIn[NUM_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcQ   <= '0;
      errQ  <= '0;
      gcfgQ <= '0;
    end else begin
      tcQ  <= (tcQ & ~tcClr) | chanDoneIn;
      errQ <= (errQ & ~errClr) | chanErrIn;
      if (cmdIn.wrEn && cmdIn.kind == RK_GCFG) gcfgQ <= wdataIn[GCFG_W-1:0];
    end
  end

  always_comb begin
    unsupNext = 1'b0;
    if (cmdIn.wrEn) begin
      case (cmdIn.kind)
        RK_SOFTREQ: unsupNext = 1'b1;
        RK_GCFG:    unsupNext = |wdataIn[2:1];
        RK_CFG:     unsupNext = wdataIn[CFG_FLOW_H];
        default:    unsupNext = 1'b0;
      endcase
    end
  end

  always_comb begin
    rdNext = '0;
    case (cmdIn.kind)
      RK_COMB:    rdNext[NUM_CH-1:0] = (tcQ & tcMask) | (errQ & errMask);
      RK_TCMSK:   rdNext[NUM_CH-1:0] = tcQ & tcMask;
      RK_ERRMSK:  rdNext[NUM_CH-1:0] = errQ & errMask;
      RK_TCRAW:   rdNext[NUM_CH-1:0] = tcQ;
      RK_ERRRAW:  rdNext[NUM_CH-1:0] = errQ;
      RK_ENABLED: rdNext[NUM_CH-1:0] = enMap;
      RK_GCFG:    rdNext[GCFG_W-1:0] = gcfgQ;
      RK_ID:      rdNext[7:0]        = idByte(NUM_CH, cmdIn.idIdx);
      RK_SRC, RK_DST, RK_CFG: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (cmdIn.chan == 3'(c)) begin
            if (cmdIn.kind == RK_SRC)      rdNext = srcQ[c];
            else if (cmdIn.kind == RK_DST) rdNext = dstQ[c];
            else                           rdNext[CFG_W-1:0] = cfgQ[c];
          end
        end
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataOut  <= '0;
      decErrOut <= 1'b0;
      unsupOut  <= 1'b0;
    end else begin
      rdataOut  <= cmdIn.rdEn ? rdNext : '0;
      decErrOut <= cmdIn.bad;
      unsupOut  <= unsupNext;
    end
  end

  assign irqOut    = |((tcQ & tcMask) | (errQ & errMask));
  assign ctrlEnOut = gcfgQ[0];
  assign tcRawOut  = tcQ;
  assign errRawOut = errQ;

endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              wrIn,
  input  logic [11:0]       addrIn,
  input  logic [31:0]       wdataIn,
  input  logic [NUM_CH-1:0] chanDoneIn,
  input  logic [NUM_CH-1:0] chanErrIn,
  output logic [31:0]       rdataOut,
  output logic              decErrOut,
  output logic              unsupOut,
  output logic              irqOut,
  output logic              ctrlEnOut
);
  busCmd_t           busCmd;
  logic [NUM_CH-1:0] tcRaw, errRaw;

  dmac_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .selIn (selIn),
    .wrIn  (wrIn),
    .addrIn(addrIn),
    .cmdOut(busCmd)
  );

  dmac_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmdIn     (busCmd),
    .wdataIn   (wdataIn),
    .chanDoneIn(chanDoneIn),
    .chanErrIn (chanErrIn),
    .rdataOut  (rdataOut),
    .decErrOut (decErrOut),
    .unsupOut  (unsupOut),
    .irqOut    (irqOut),
    .ctrlEnOut (ctrlEnOut),
    .tcRawOut  (tcRaw),
    .errRawOut (errRaw)
  );

endmodule

// File: rtl/dmac_regif_chk.sv
module dmac_regif_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              selIn,
  input logic              wrIn,
  input logic [11:0]       addrIn,
  input logic [31:0]       wdataIn,
  input logic [NUM_CH-1:0] chanDoneIn,
  input logic [NUM_CH-1:0] chanErrIn,
  input logic [31:0]       rdataOut,
  input logic              decErrOut,
  input logic              unsupOut,
  input logic              irqOut,
  input logic              ctrlEnOut,
  input logic [NUM_CH-1:0] tcRaw,
  input logic [NUM_CH-1:0] errRaw
);
  localparam logic [3:0] NCH4 = 4'(NUM_CH);

  logic holeHit, chanOver;
  assign holeHit  = selIn && addrIn >= 12'h200 && addrIn < 12'hFE0;
  assign chanOver = selIn && addrIn[11:8] == 4'h1 && {1'b0, addrIn[7:5]} >= NCH4;

  a_r2_hole_flag: assert property (@(posedge clk) disable iff (!rstN)
    holeHit |=> decErrOut);
  a_r2_chan_flag: assert property (@(posedge clk) disable iff (!rstN)
    chanOver |=> decErrOut);
  a_r2_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (holeHit && !wrIn) |=> (rdataOut == 32'd0));
  a_r3_id_first: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && !wrIn && addrIn == 12'hFE0) |=> (rdataOut[7:4] == 4'h8));
  a_r4_enable: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && wrIn && addrIn[11:2] == 10'd12) |=> (ctrlEnOut == $past(wdataIn[0])));
  a_r5_tc_set: assert property (@(posedge clk) disable iff (!rstN)
    (|chanDoneIn) |=> ((tcRaw & $past(chanDoneIn)) == $past(chanDoneIn)));
  a_r5_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (|chanErrIn) |=> ((errRaw & $past(chanErrIn)) == $past(chanErrIn)));
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (tcRaw == '0 && errRaw == '0) |-> !irqOut);
  a_r10_soft_unsup: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && wrIn && (addrIn[11:2] == 10'd8 || addrIn[11:2] == 10'd9)) |=> unsupOut);

endmodule

bind dmac_regif dmac_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .selIn(selIn), .wrIn(wrIn), .addrIn(addrIn),
  .wdataIn(wdataIn), .chanDoneIn(chanDoneIn), .chanErrIn(chanErrIn),
  .rdataOut(rdataOut), .decErrOut(decErrOut), .unsupOut(unsupOut),
  .irqOut(irqOut), .ctrlEnOut(ctrlEnOut), .tcRaw(tcRaw), .errRaw(errRaw)
);

// File: tb/tb_dmac_regif.sv
module tb_dmac_regif;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0, sel2 = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  done = '0, err = '0;
  logic [1:0]  zero2 = '0;
  logic [31:0] rdata, rdata2;
  logic        decErr, unsup, irq, ctrlEn;
  logic        decErr2, unsup2, irq2, ctrlEn2;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] srcM [8];
  logic [31:0] dstM [8];
  logic [15:0] cfgM [8];
  logic [7:0]  tcM = '0, errM = '0;
  logic [2:0]  gcfgM = '0;

  always #10 clk = ~clk;

  dmac_regif #(.NUM_CH(8)) dut (
    .clk(clk), .rstN(rstN), .selIn(sel), .wrIn(wr), .addrIn(addr), .wdataIn(wdata),
    .chanDoneIn(done), .chanErrIn(err), .rdataOut(rdata), .decErrOut(decErr),
    .unsupOut(unsup), .irqOut(irq), .ctrlEnOut(ctrlEn));

  dmac_regif #(.NUM_CH(2)) dut2 (
    .clk(clk), .rstN(rstN), .selIn(sel2), .wrIn(wr), .addrIn(addr), .wdataIn(wdata),
    .chanDoneIn(zero2), .chanErrIn(zero2), .rdataOut(rdata2), .decErrOut(decErr2),
    .unsupOut(unsup2), .irqOut(irq2), .ctrlEnOut(ctrlEn2));

  function automatic logic [7:0] maskOf(input int bitPos);
    logic [7:0] m = '0;
    for (int c = 0; c < 8; c++) m[c] = cfgM[c][bitPos];
    return m;
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    logic [7:0] tcv = tcM & maskOf(14);
    logic [7:0] erv = errM & maskOf(15);
    if (a >= 12'h100 && a < 12'h200) begin
      int ch = (int'(a) - 256) / 32;
      int off = (int'(a) - 256) % 32;
      if (off == 0) return srcM[ch];
      if (off == 4) return dstM[ch];
      if (off == 8) return {16'd0, cfgM[ch]};
      return 0;
    end
    case (a)
      12'h000: return {24'd0, tcv | erv};
      12'h004: return {24'd0, tcv};
      12'h00C: return {24'd0, erv};
      12'h014: return {24'd0, tcM};
      12'h018: return {24'd0, errM};
      12'h01C: return {24'd0, maskOf(0)};
      12'h030: return {29'd0, gcfgM};
      default: return 0;
    endcase
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a >= 12'h100 && a < 12'h200) begin
      int ch = (int'(a) - 256) / 32;
      int off = (int'(a) - 256) % 32;
      if (off == 0) srcM[ch] = d;
      if (off == 4) dstM[ch] = d;
      if (off == 8) cfgM[ch] = d[15:0];
    end else if (a == 12'h008) tcM = tcM & ~d[7:0];
    else if (a == 12'h010) errM = errM & ~d[7:0];
    else if (a == 12'h030) gcfgM = d[2:0];
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic expIrq;
      expIrq = |((tcM & maskOf(14)) | (errM & maskOf(15)));
      chk(irq == expIrq, "R7 irqOut per cycle", {31'd0, irq}, {31'd0, expIrq});
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input bit expU,
                          input bit expD, input string tag);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    sel = 0; wr = 0;
    chk(unsup == expU, {tag, " unsupOut"}, {31'd0, unsup}, {31'd0, expU});
    chk(decErr == expD, {tag, " decErrOut"}, {31'd0, decErr}, {31'd0, expD});
  endtask

  task automatic busRead(input logic [11:0] a, input bit expD, input string tag);
    logic [31:0] exp;
    exp = expD ? 32'd0 : ((a >= 12'hFE0) ? 32'd0 : modelRead(a));
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
    chk(rdata == exp, {tag, " rdata"}, rdata, exp);
    chk(decErr == expD, {tag, " decErrOut"}, {31'd0, decErr}, {31'd0, expD});
  endtask

  task automatic readIdx(input bit second, input logic [11:0] a, input logic [31:0] exp,
                         input bit expD, input string tag);
    @(negedge clk);
    if (second) sel2 = 1; else sel = 1;
    wr = 0; addr = a;
    @(negedge clk);
    sel = 0; sel2 = 0;
    if (second) begin
      chk(rdata2 == exp, {tag, " rdata"}, rdata2, exp);
      chk(decErr2 == expD, {tag, " decErrOut"}, {31'd0, decErr2}, {31'd0, expD});
    end else begin
      chk(rdata == exp, {tag, " rdata"}, rdata, exp);
      chk(decErr == expD, {tag, " decErrOut"}, {31'd0, decErr}, {31'd0, expD});
    end
  endtask

  task automatic strobe(input logic [7:0] dm, input logic [7:0] em);
    @(negedge clk);
    done = dm; err = em;
    @(posedge clk);
    tcM = tcM | dm; errM = errM | em;
    @(negedge clk);
    done = '0; err = '0;
  endtask

  task automatic doneWithClear(input logic [7:0] m);
    @(negedge clk);
    sel = 1; wr = 1; addr = 12'h008; wdata = {24'd0, m}; done = m;
    @(posedge clk);
    tcM = (tcM & ~m) | m;
    @(negedge clk);
    sel = 0; wr = 0; done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [7:0] idSeq [8];

  initial begin
    idSeq[0] = 8'h80; idSeq[1] = 8'h10; idSeq[2] = 8'h04; idSeq[3] = 8'h0A;
    idSeq[4] = 8'h0D; idSeq[5] = 8'hF0; idSeq[6] = 8'h05; idSeq[7] = 8'hB1;
    for (int c = 0; c < 8; c++) begin srcM[c] = '0; dstM[c] = '0; cfgM[c] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;

    // R11 reset state
    chk(ctrlEn == 0 && unsup == 0 && decErr == 0 && irq == 0, "R11 outputs after reset",
        {28'd0, ctrlEn, unsup, decErr, irq}, 32'd0);
    busRead(12'h000, 0, "R11 combined");
    busRead(12'h01C, 0, "R11 enabled");
    busRead(12'h030, 0, "R11 gcfg");
    busRead(12'h1E4, 0, "R11 ch7 dst");

    // R1 channel registers
    busWrite(12'h100, 32'hDEADBEEF, 0, 0, "R1 ch0 src");
    busWrite(12'h104, 32'h12345678, 0, 0, "R1 ch0 dst");
    busWrite(12'h108, 32'hFFFF4001, 0, 0, "R1 ch0 cfg");
    busWrite(12'h1E0, 32'hA5A5A5A5, 0, 0, "R1 ch7 src");
    busWrite(12'h1E8, 32'h00008001, 0, 0, "R1 ch7 cfg");
    busRead(12'h100, 0, "R1 ch0 src");
    busRead(12'h104, 0, "R1 ch0 dst");
    busRead(12'h108, 0, "R1 ch0 cfg upper dropped");
    busRead(12'h1E0, 0, "R1 ch7 src");
    busRead(12'h1E8, 0, "R1 ch7 cfg");

    // R8 enabled map
    busRead(12'h01C, 0, "R8 enabled map");

    // R5 strobes
    strobe(8'h05, 8'h00);
    strobe(8'h00, 8'h80);
    busRead(12'h014, 0, "R5 raw tc");
    busRead(12'h018, 0, "R5 raw err");

    // R7 masked views
    busRead(12'h004, 0, "R7 masked tc");
    busRead(12'h00C, 0, "R7 masked err");
    busRead(12'h000, 0, "R7 combined");
    chk(irq == 1, "R7 irq high", {31'd0, irq}, 32'd1);

    // R6 write-one-to-clear and priority
    busWrite(12'h008, 32'h1, 0, 0, "R6 clear tc0");
    busRead(12'h014, 0, "R6 tc after clear");
    busWrite(12'h010, 32'h80, 0, 0, "R6 clear err7");
    busRead(12'h018, 0, "R6 err after clear");
    chk(irq == 0, "R6 irq low after clears", {31'd0, irq}, 32'd0);
    doneWithClear(8'h01);
    busRead(12'h014, 0, "R6 set wins over clear");
    chk(irq == 1, "R6 irq after set-wins", {31'd0, irq}, 32'd1);
    busWrite(12'h008, 32'h05, 0, 0, "R6 clear all");
    busRead(12'h014, 0, "R6 tc cleared");

    // R4 global configuration
    busWrite(12'h030, 32'h1, 0, 0, "R4 enable");
    chk(ctrlEn == 1, "R4 ctrlEnOut set", {31'd0, ctrlEn}, 32'd1);
    busRead(12'h030, 0, "R4 readback");
    busWrite(12'h030, 32'h2, 1, 0, "R4 endian select");
    chk(ctrlEn == 0, "R4 ctrlEnOut clear", {31'd0, ctrlEn}, 32'd0);
    busWrite(12'h030, 32'h5, 1, 0, "R4 endian select 2");
    busRead(12'h030, 0, "R4 readback 2");

    // R9 flow field
    busWrite(12'h128, 32'h2000, 1, 0, "R9 flow 4");
    busRead(12'h128, 0, "R9 stored");
    busWrite(12'h128, 32'h1800, 0, 0, "R9 flow 3");
    busWrite(12'h128, 32'h3800, 1, 0, "R9 flow 7");

    // R10 software request words
    strobe(8'h02, 8'h00);
    busWrite(12'h020, 32'hFF, 1, 0, "R10 soft burst");
    busWrite(12'h024, 32'hFF, 1, 0, "R10 soft single");
    busRead(12'h020, 0, "R10 soft read");
    busRead(12'h014, 0, "R10 status untouched");

    // R2 bad offsets
    busRead(12'h040, 1, "R2 global hole");
    busRead(12'h300, 1, "R2 window hole");
    busWrite(12'h10C, 32'h55, 0, 1, "R2 stride hole write");
    busRead(12'h100, 0, "R2 ch0 src unchanged");
    busWrite(12'hFE0, 32'h0, 0, 1, "R2 id write");
    busRead(12'h10C, 1, "R2 stride hole read");
    readIdx(1, 12'h140, 32'd0, 1, "R2 two-channel index 2");
    readIdx(1, 12'h1E0, 32'd0, 1, "R2 two-channel index 7");
    readIdx(1, 12'h120, 32'd0, 0, "R2 two-channel index 1");

    // R3 identification
    for (int k = 0; k < 8; k++)
      readIdx(0, 12'hFE0 + 12'(4 * k), {24'd0, idSeq[k]}, 0, "R3 id byte");
    readIdx(1, 12'hFE0, 32'h81, 0, "R3 two-channel first id");
    readIdx(1, 12'hFFC, 32'hB1, 0, "R3 two-channel last id");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule